// File: doc/BRIEF.md
# Video Memory Shift Clock Generator with Split-Transfer Pulse

This block produces the serial shift clock for video memories. Outside blanking it passes the pixel-derived shift clock level (`shift_src`) to the output. When blanking starts (`blank_n` goes low), it lets a programmable number of further full shift pulses through. This covers data still in flight behind the pixel-clock sample and latch delay. After that it holds the output low.

While blanking is active, a rising edge on the transfer flag inserts one extra, timed shift pulse. This happens only when split transfers are enabled and the nibble mode is off. The pulse lets the memories complete a split shift-register transfer.

Everything runs on a fast reference clock, 5 ns at the default settings. `shift_src`, `blank_n` and the control bits are expected to be synchronous to that clock. The flag input is asynchronous and passes through a synchronizer before its rising edge is detected.

Top module: `vram_sclk_gen`

## Requirements
- R1: While reset is asserted, `sclk` is low.
- R2: While the gate is open and no pulse is being inserted, `sclk` equals the value `shift_src` had at the previous rising edge of `clk` (one register of latency).
- R3: When `blank_n` falls while `shift_src` is low, exactly `LAG_PULSES` (default 2) further complete shift pulses appear on `sclk`, each as wide as its source pulse. The gate then closes on the next low phase of `shift_src`. The gate only closes while blanking is active.
- R4: During blanking, once the gate is closed and no pulse is being inserted, `sclk` stays low.
- R5: With `split_en` = 1, `nibble_mode` = 0 and `blank_n` = 0, a rising edge of `xfer_flag` gives one pulse. Counting the first `clk` edge that samples the flag high as edge 1, `sclk` is high after edges 5 through 8 (4 cycles, 20 ns) and low after edges 1 to 4 and after edge 9, at the default parameters.
- R6: With `split_en` = 0, a flag rising edge inserts no pulse.
- R7: With `nibble_mode` = 1, a flag rising edge inserts no pulse.
- R8: A flag held high gives exactly one pulse. A new pulse needs the flag to be low and then rise again.
- R9: A flag rising edge while `blank_n` = 1 inserts no pulse, and `sclk` keeps following `shift_src`.
- R10: A flag rising edge detected while an inserted pulse is still being timed is dropped, so no second pulse follows.
- R11: A flag that is still high after `blank_n` returns high, and falls a few cycles later, does not disturb the normal shift pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (5 ns period) |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_src | input | 1 | Pixel-derived shift clock level, synchronous to `clk` |
| blank_n | input | 1 | Blanking, active low |
| xfer_flag | input | 1 | Split-transfer request flag, asynchronous |
| split_en | input | 1 | Split-transfer insertion enable |
| nibble_mode | input | 1 | Special nibble mode; 1 blocks insertion |
| sclk | output | 1 | Shift clock to the video memories |

## Verification
The hardest situation to reach from the ports is a second flag edge that arrives after the synchronizer while the first inserted pulse is still being timed (R10). The bench counts clock edges from the moment it raises the flag. It drops the flag for exactly one cycle at a chosen edge, so the resynchronized second rise lands inside the timer window. It then checks that only one pulse appears.

A second hard case is a flag that stays high after blanking ends. The bench reopens the gate at a fixed phase of `shift_src` and releases the flag two cycles later. It compares every following output cycle with the delayed source.

// File: rtl/vram_sclk_pkg.sv
package vram_sclk_pkg;
   typedef enum logic {
      GATE_PASS = 1'b0,
      GATE_SHUT = 1'b1
   } gate_state_t;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/vram_flag_edge.sv
module vram_flag_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_async,
   output logic flag_rise
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vram_flag_edge: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q[i] <= 1'b0;
            end else if (i == 0) begin
               sync_q[i] <= flag_async;
            end else begin
               sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign flag_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/vram_ins_timer.sv
module vram_ins_timer #(
   parameter int unsigned INS_DELAY = 2,
   parameter int unsigned INS_WIDTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic busy,
   output logic pulse
);
   import vram_sclk_pkg::*;

   localparam int unsigned TOTAL = INS_DELAY + INS_WIDTH;
   localparam int unsigned CW    = cnt_bits(TOTAL);

   logic [CW-1:0] cnt_q;

   generate
      if (INS_DELAY < 1) begin : g_bad_delay
         $error("vram_ins_timer: INS_DELAY must be at least 1");
      end
      if (INS_WIDTH < 1) begin : g_bad_width
         $error("vram_ins_timer: INS_WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == '0) begin
         if (fire) cnt_q <= CW'(1);
      end else if (cnt_q == CW'(TOTAL - 1)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign busy  = (cnt_q != '0);
   assign pulse = (cnt_q >= CW'(INS_DELAY)) && (cnt_q < CW'(TOTAL));
endmodule

// File: rtl/vram_lag_gate.sv
module vram_lag_gate #(
   parameter int unsigned LAG_PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic blank_n,
   input  logic src,
   output logic pass
);
   import vram_sclk_pkg::*;

   localparam int unsigned LW = cnt_bits(LAG_PULSES);

   gate_state_t   state_q;
   logic [LW-1:0] lag_q;
   logic          src_q;
   logic          src_rise;
   logic          lag_done;

   assign src_rise = src & ~src_q;
   assign lag_done = (lag_q == LW'(LAG_PULSES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GATE_PASS;
         lag_q   <= '0;
         src_q   <= 1'b0;
      end else begin
         src_q <= src;
         unique case (state_q)
            GATE_PASS: begin
               if (blank_n) begin
                  lag_q <= '0;
               end else if (lag_done && !src) begin
                  state_q <= GATE_SHUT;
               end else if (src_rise && !lag_done) begin
                  lag_q <= lag_q + LW'(1);
               end
            end
            GATE_SHUT: begin
               if (blank_n && !src) begin
                  state_q <= GATE_PASS;
                  lag_q   <= '0;
               end
            end
            default: state_q <= GATE_PASS;
         endcase
      end
   end

   assign pass = (state_q == GATE_PASS);
endmodule

// File: rtl/vram_sclk_gen.sv
module vram_sclk_gen #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned INS_DELAY   = 2,
   parameter int unsigned INS_WIDTH   = 4,
   parameter int unsigned LAG_PULSES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_src,
   input  logic blank_n,
   input  logic xfer_flag,
   input  logic split_en,
   input  logic nibble_mode,
   output logic sclk
);
   logic flag_rise;
   logic fire;
   logic ins_busy;
   logic ins_on;
   logic gate_pass;
   logic sclk_q;

   vram_flag_edge #(.STAGES(SYNC_STAGES)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .flag_async (xfer_flag),
      .flag_rise  (flag_rise)
   );

   assign fire = flag_rise & split_en & ~nibble_mode & ~blank_n;

   vram_ins_timer #(.INS_DELAY(INS_DELAY), .INS_WIDTH(INS_WIDTH)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .busy  (ins_busy),
      .pulse (ins_on)
   );

   vram_lag_gate #(.LAG_PULSES(LAG_PULSES)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .blank_n (blank_n),
      .src     (shift_src),
      .pass    (gate_pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= (shift_src & gate_pass) | ins_on;
   end

   assign sclk = sclk_q;
endmodule

// File: rtl/vram_sclk_chk.sv
module vram_sclk_chk #(
   parameter int unsigned INS_WIDTH = 4
) (
   input logic clk,
   input logic rst_n,
   input logic shift_src,
   input logic blank_n,
   input logic split_en,
   input logic nibble_mode,
   input logic sclk,
   input logic gate_pass,
   input logic ins_busy,
   input logic ins_on
);
   localparam int unsigned RW = $clog2(INS_WIDTH + 2);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        run_q <= '0;
      else if (!ins_on)                  run_q <= '0;
      else if (run_q != RW'(INS_WIDTH + 1)) run_q <= run_q + RW'(1);
   end

   assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !sclk);

   assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_pass && !ins_on) |=> (sclk == $past(shift_src)));

   assert_close_in_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_pass) |-> !$past(blank_n));

   assert_shut_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_pass && !ins_on) |=> !sclk);

   assert_width_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ins_on |-> (run_q < RW'(INS_WIDTH)));

   assert_width_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ins_on) |-> (run_q == RW'(INS_WIDTH)));

   assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ins_busy) |-> $past(split_en && !nibble_mode && !blank_n));
endmodule

bind vram_sclk_gen vram_sclk_chk #(.INS_WIDTH(INS_WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .shift_src   (shift_src),
   .blank_n     (blank_n),
   .split_en    (split_en),
   .nibble_mode (nibble_mode),
   .sclk        (sclk),
   .gate_pass   (gate_pass),
   .ins_busy    (ins_busy),
   .ins_on      (ins_on)
);

// File: tb/test_vram_sclk_gen.sv
`timescale 1ns/1ps
module test_vram_sclk_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_src = 1'b0;
   logic blank_n = 1'b1;
   logic xfer_flag = 1'b0;
   logic split_en = 1'b0;
   logic nibble_mode = 1'b0;
   logic sclk;

   int vectors = 0;
   int errors  = 0;
   int cyc     = 0;
   int phase   = 0;
   logic src_at_pos = 1'b0;

   always #2.5 clk = ~clk;

   vram_sclk_gen i_vram_sclk_gen (
      .clk(clk), .rst_n(rst_n), .shift_src(shift_src), .blank_n(blank_n),
      .xfer_flag(xfer_flag), .split_en(split_en), .nibble_mode(nibble_mode),
      .sclk(sclk)
   );

   // source shift clock: 4 cycles high, 4 low, changing at the falling edge
   always @(negedge clk) begin
      phase     <= (phase == 7) ? 0 : phase + 1;
      shift_src <= (((phase == 7) ? 0 : phase + 1) < 4);
   end

   always @(posedge clk) src_at_pos <= shift_src;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 50000) begin
         errors++;
         $display("FAIL timeout: cycles %0d expected < %0d", cyc, 50000);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic align_low();
      do tick(); while (phase != 4);
   endtask

   task automatic count_pulses(input int n, output int rises, output int highs);
      logic prev;
      prev  = sclk;
      rises = 0;
      highs = 0;
      for (int i = 0; i < n; i++) begin
         tick();
         if (sclk && !prev) rises++;
         if (sclk) highs++;
         prev = sclk;
      end
   endtask

   task automatic follow_src(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         tick();
         check(sclk == src_at_pos, req, sclk, src_at_pos);
      end
   endtask

   task automatic enter_blank();
      align_low();
      blank_n = 1'b0;
      repeat (30) tick();
   endtask

   task automatic leave_blank();
      align_low();
      blank_n = 1'b1;
   endtask

   task automatic t_reset();
      for (int i = 0; i < 5; i++) begin
         tick();
         check(sclk == 1'b0, "R1", sclk, 0);
      end
      rst_n = 1'b1;
   endtask

   task automatic t_pass();
      follow_src(24, "R2");
   endtask

   task automatic t_lag();
      int r, h;
      align_low();
      blank_n = 1'b0;
      count_pulses(40, r, h);
      check(r == 2, "R3 pulse count", r, 2);
      check(h == 8, "R3 high cycles", h, 8);
      count_pulses(24, r, h);
      check(h == 0, "R4 held low", h, 0);
   endtask

   // expects the gate shut; raises the flag and checks the exact pulse shape
   task automatic t_insert_shape(input string req);
      xfer_flag = 1'b1;
      for (int k = 1; k <= 10; k++) begin
         tick();
         check(sclk == ((k >= 5) && (k <= 8)), req, sclk, (k >= 5) && (k <= 8));
      end
   endtask

   task automatic t_insert();
      split_en = 1'b1;
      nibble_mode = 1'b0;
      t_insert_shape("R5");
      xfer_flag = 1'b0;
      repeat (10) tick();
   endtask

   task automatic t_blocked(input bit en, input bit nib, input string req);
      int r, h;
      split_en = en;
      nibble_mode = nib;
      xfer_flag = 1'b1;
      count_pulses(20, r, h);
      check(h == 0, req, h, 0);
      xfer_flag = 1'b0;
      repeat (10) tick();
      split_en = 1'b1;
      nibble_mode = 1'b0;
   endtask

   task automatic t_held();
      int r, h;
      xfer_flag = 1'b1;
      count_pulses(40, r, h);
      check(r == 1, "R8 single pulse while held", r, 1);
      check(h == 4, "R8 pulse width", h, 4);
      xfer_flag = 1'b0;
      repeat (6) tick();
      t_insert_shape("R8 re-arm");
      xfer_flag = 1'b0;
      repeat (10) tick();
   endtask

   task automatic t_busy();
      int r, h;
      logic prev;
      xfer_flag = 1'b1;
      r = 0;
      h = 0;
      prev = sclk;
      for (int k = 1; k <= 30; k++) begin
         tick();
         if (k == 3) xfer_flag = 1'b0;
         if (k == 4) xfer_flag = 1'b1;
         if (sclk && !prev) r++;
         if (sclk) h++;
         prev = sclk;
      end
      check(r == 1, "R10 retrigger dropped", r, 1);
      check(h == 4, "R10 high cycles", h, 4);
      xfer_flag = 1'b0;
      repeat (10) tick();
   endtask

   task automatic t_outside();
      leave_blank();
      xfer_flag = 1'b1;
      follow_src(20, "R9");
      xfer_flag = 1'b0;
      repeat (4) tick();
   endtask

   task automatic t_late_release();
      enter_blank();
      xfer_flag = 1'b1;
      repeat (12) tick();
      align_low();
      blank_n = 1'b1;
      tick();
      check(sclk == src_at_pos, "R11", sclk, src_at_pos);
      tick();
      check(sclk == src_at_pos, "R11", sclk, src_at_pos);
      xfer_flag = 1'b0;
      follow_src(30, "R11");
   endtask

   initial begin
      t_reset();
      repeat (3) tick();
      t_pass();
      t_lag();
      t_insert();
      t_blocked(1'b0, 1'b0, "R6");
      t_blocked(1'b1, 1'b1, "R7");
      t_held();
      t_busy();
      t_outside();
      t_late_release();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule